// File: doc/BRIEF.md
# Power-of-two PWM timer with buffered compare

The block counts ticks of an external clock enable with an 8-bit up counter and drives one PWM output from an output flip-flop. The period is a power of two, 2^n ticks, with n picked by a two-bit mode field. A compare value sets the duty point. Counting starts from 0 with the output cleared. The output inverts when the counter reaches the compare value, and it inverts again when the counter wraps at the end of the period. The low phase therefore lasts exactly the compare value in ticks.

Compare writes can go through a shadow buffer. While buffering is on, a new value waits in the buffer and is copied into the active compare register only on the period wrap. A duty change therefore never cuts a cycle short. While buffering is off, a write lands in the active register at once.

Software-style control is plain level and pulse pins: run, mode, a compare write strobe with data, a flip-flop clear pulse, an inversion enable and a buffer enable. No pin carries a data stream, so no pin has a valid/ready handshake. A one-clock pulse marks each period wrap.

Top module: `pwm2n_timer`

## Requirements
- R1: After reset, pwm_out is 0 and ovf_pulse is 0.
- R2: With dbuf_en high, a compare write leaves the active compare value unchanged until the next period wrap, and that wrap loads the written value.
- R3: With dbuf_en low, a compare write takes effect in the active compare value on the next clock.
- R4: The period is 2^n ticks, with mode 2'b01 giving n=6 (64 ticks), 2'b10 giving n=7 (128 ticks), 2'b11 giving n=8 (256 ticks), and the reserved 2'b00 behaving as n=8.
- R5: After the output is cleared and counting starts from 0 with inversion enabled, pwm_out is 1 after k ticks exactly when compare <= k < 2^n, and it returns to 0 at tick 2^n.
- R6: A compare value of 0, or one larger than 2^n-1, never matches, so the output toggles only at the period wrap.
- R7: ovf_pulse is high for exactly the one clock after the tick on which the counter wraps from 2^n-1 to 0, and low after every other tick.
- R8: With inv_en low, pwm_out does not change on match or wrap, while the counter still runs and ovf_pulse still fires every 2^n ticks.
- R9: ff_clr forces pwm_out to 0 on the next clock, overriding any toggle, and does not disturb the counter.
- R10: run low clears the counter to 0 and keeps pwm_out. After run returns high, counting restarts from 0.
- R11: The counter, pwm_out and ovf_pulse change only on cycles with tick_en high. Idle cycles in between do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable from a prescaler, one tick per high cycle |
| run | input | 1 | Count when high, hold the counter at 0 when low |
| mode | input | 2 | Period select, 01=64, 10=128, 11=256, 00=256 ticks |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| ff_clr | input | 1 | Pulse that clears the output flip-flop |
| inv_en | input | 1 | Allow match and wrap events to invert the output |
| dbuf_en | input | 1 | Route compare writes through the shadow buffer |
| pwm_out | output | 1 | PWM output level |
| ovf_pulse | output | 1 | One-clock pulse at each period wrap |

## Verification
The bench counts ticks exactly and looks at the output on both sides of the match and the wrap. A design that is off by one in the compare produces a low phase of compare±1 ticks and fails at tick compare-1 or compare. A compare write during a buffered period must not move the current period's edge. A design that bypasses the buffer moves the edge early, and one that never loads the buffer keeps the old duty in the next period. The bench also covers the reserved mode code, a compare of 0, a compare beyond the period, a clear in mid-period followed by an inverted wrap, and a stop/restart. A design that does not clear the counter on stop misses the expected match after restart.

// File: rtl/pwm2n_pkg.sv
package pwm2n_pkg;
  typedef enum logic [1:0] {
    MODE_RSVD  = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_MID   = 2'b10,
    MODE_FULL  = 2'b11
  } pwm_mode_e;

  // right-shift applied to an all-ones mask to form the last count
  function automatic logic [1:0] mode_shift(input logic [1:0] m);
    logic [1:0] s;
    case (pwm_mode_e'(m))
      MODE_SHORT: s = 2'd2;
      MODE_MID:   s = 2'd1;
      default:    s = 2'd0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pwm2n_counter.sv
module pwm2n_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] last,
  input  logic [CNT_W-1:0] cmp,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             ovf_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             step;

  assign step      = run && tick_en;
  assign cnt_inc   = cnt_q + 1'b1;
  // >= so that a shorter period chosen mid-count still wraps
  assign ovf_evt   = step && (cnt_q >= last);
  assign match_evt = step && !ovf_evt && (cnt_inc == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_evt;
      if (!run)         cnt_q <= '0;
      else if (ovf_evt) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_inc;
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R10
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_en) |=> $stable(cnt_q)); // R11
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R7
endmodule

// File: rtl/pwm2n_cmpbuf.sv
module pwm2n_cmpbuf #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dbuf_en,
  input  logic             load,
  output logic [CNT_W-1:0] active
);
  logic [CNT_W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active   <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (!dbuf_en && wr)      active <= wdata;
      else if (dbuf_en && load) active <= shadow_q;
    end
  end

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !load) |=> $stable(active)); // R2
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && wr) |=> (active == $past(wdata))); // R3
endmodule

// File: rtl/pwm2n_outff.sv
module pwm2n_outff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inv_en,
  input  logic match_evt,
  input  logic ovf_evt,
  output logic pwm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            pwm <= 1'b0;
    else if (clr)                          pwm <= 1'b0;
    else if (inv_en && (match_evt || ovf_evt)) pwm <= ~pwm;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pwm); // R9
  AST_INV_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en && !clr) |=> $stable(pwm)); // R8
endmodule

// File: rtl/pwm2n_timer.sv
module pwm2n_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ff_clr,
  input  logic             inv_en,
  input  logic             dbuf_en,
  output logic             pwm_out,
  output logic             ovf_pulse
);
  import pwm2n_pkg::*;

  localparam logic [CNT_W-1:0] FULL_MASK = {CNT_W{1'b1}};

  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] cmp_active;
  logic             ovf_evt;
  logic             match_evt;

  assign last = FULL_MASK >> mode_shift(mode);

  pwm2n_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .last(last), .cmp(cmp_active),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .ovf_pulse(ovf_pulse)
  );

  pwm2n_cmpbuf #(.CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
    .dbuf_en(dbuf_en), .load(ovf_evt), .active(cmp_active)
  );

  pwm2n_outff u_ff (
    .clk(clk), .rst_n(rst_n), .clr(ff_clr), .inv_en(inv_en),
    .match_evt(match_evt), .ovf_evt(ovf_evt), .pwm(pwm_out)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick_en) |=> !ovf_pulse); // R11
endmodule

// File: tb/sim_pwm2n_timer.sv
module sim_pwm2n_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       run = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'h00;
  logic       ff_clr = 1'b0;
  logic       inv_en = 1'b1;
  logic       dbuf_en = 1'b0;
  logic       pwm_out;
  logic       ovf_pulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pwm2n_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .mode(mode),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ff_clr(ff_clr),
    .inv_en(inv_en), .dbuf_en(dbuf_en), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  task automatic setup(input logic [1:0] m, input int c, input logic inv, input logic db);
    @(negedge clk);
    run = 1'b0; dbuf_en = 1'b0; cmp_wr = 1'b1; cmp_wdata = c[7:0];
    ff_clr = 1'b1; mode = m; inv_en = inv;
    @(negedge clk);
    cmp_wr = 1'b0; ff_clr = 1'b0; dbuf_en = db; run = 1'b1;
  endtask

  task automatic write_cmp(input int c);
    @(negedge clk) begin cmp_wr = 1'b1; cmp_wdata = c[7:0]; end
    @(negedge clk) cmp_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pwm after reset", pwm_out, 0);
    check("R1 ovf after reset", ovf_pulse, 0);
  endtask

  task automatic t_low_phase();
    setup(2'b10, 100, 1'b1, 1'b1);
    ticks(99);
    check("R5 pwm at tick 99", pwm_out, 0);
    tick_once();
    check("R5 pwm at tick 100", pwm_out, 1);
    ticks(27);
    check("R5 pwm at tick 127", pwm_out, 1);
    check("R7 no ovf at tick 127", ovf_pulse, 0);
    tick_once();
    check("R5 pwm at tick 128", pwm_out, 0);
    check("R7 ovf at tick 128", ovf_pulse, 1);
    @(negedge clk);
    check("R7 ovf one clock only", ovf_pulse, 0);
  endtask

  task automatic t_dbuf();
    setup(2'b10, 100, 1'b1, 1'b1);
    ticks(10);
    write_cmp(32);
    ticks(89);
    check("R2 old compare still active at 99", pwm_out, 0);
    tick_once();
    check("R2 old compare toggles at 100", pwm_out, 1);
    ticks(28);
    check("R2 wrap at 128", pwm_out, 0);
    ticks(31);
    check("R2 new compare not yet at 31", pwm_out, 0);
    tick_once();
    check("R2 new compare toggles at 32", pwm_out, 1);
  endtask

  task automatic t_direct();
    setup(2'b10, 100, 1'b1, 1'b0);
    ticks(10);
    write_cmp(50);
    ticks(39);
    check("R3 pwm at tick 49", pwm_out, 0);
    tick_once();
    check("R3 immediate compare at 50", pwm_out, 1);
  endtask

  task automatic t_period(input logic [1:0] m, input int p);
    setup(m, 10, 1'b1, 1'b1);
    ticks(p - 1);
    check($sformatf("R4 mode %0d no ovf before %0d", m, p), ovf_pulse, 0);
    check($sformatf("R4 mode %0d high before wrap", m), pwm_out, 1);
    tick_once();
    check($sformatf("R4 mode %0d ovf at %0d", m, p), ovf_pulse, 1);
    check($sformatf("R4 mode %0d low at wrap", m), pwm_out, 0);
  endtask

  task automatic t_no_match(input int c);
    setup(2'b01, c, 1'b1, 1'b1);
    ticks(63);
    check($sformatf("R6 compare %0d no match", c), pwm_out, 0);
    tick_once();
    check($sformatf("R6 compare %0d toggle at wrap", c), pwm_out, 1);
  endtask

  task automatic t_inv_off();
    int highs = 0;
    setup(2'b10, 20, 1'b0, 1'b1);
    for (int i = 0; i < 127; i++) begin
      tick_once();
      if (pwm_out) highs++;
    end
    check("R8 output held with inversion off", highs, 0);
    tick_once();
    check("R8 ovf still fires", ovf_pulse, 1);
    check("R8 output held at wrap", pwm_out, 0);
  endtask

  task automatic t_clear();
    setup(2'b10, 20, 1'b1, 1'b1);
    ticks(30);
    check("R9 high before clear", pwm_out, 1);
    @(negedge clk) ff_clr = 1'b1;
    @(negedge clk) ff_clr = 1'b0;
    check("R9 cleared", pwm_out, 0);
    ticks(97);
    check("R9 counter kept at 127", ovf_pulse, 0);
    tick_once();
    check("R9 wrap inverts cleared output", pwm_out, 1);
    check("R9 wrap at 128 unchanged", ovf_pulse, 1);
  endtask

  task automatic t_stop();
    setup(2'b10, 20, 1'b1, 1'b1);
    ticks(50);
    @(negedge clk) run = 1'b0;
    @(negedge clk) run = 1'b1;
    check("R10 output kept across stop", pwm_out, 1);
    ticks(19);
    check("R10 no match before 20 after restart", pwm_out, 1);
    tick_once();
    check("R10 match at 20 after restart", pwm_out, 0);
  endtask

  task automatic t_gating();
    setup(2'b10, 5, 1'b1, 1'b1);
    ticks(4);
    repeat (50) @(negedge clk);
    check("R11 idle cycles do not count", pwm_out, 0);
    check("R11 no ovf while idle", ovf_pulse, 0);
    tick_once();
    check("R11 fifth tick matches", pwm_out, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_phase();
    t_dbuf();
    t_direct();
    t_period(2'b01, 64);
    t_period(2'b10, 128);
    t_period(2'b11, 256);
    t_period(2'b00, 256);
    t_no_match(0);
    t_no_match(200);
    t_inv_off();
    t_clear();
    t_stop();
    t_gating();
    finish_run();
  end
endmodule